// File: doc/BRIEF.md
# Multi-Class Reset Controller

This block turns several reset sources into a set of reset outputs, each with a different reach. The sources are an asynchronous power-good input, an active-low external hard-reset pin, single-cycle configuration-write reset requests and an internal fatal-error pulse. The outputs are: a reset for sticky state; a reset for non-sticky state and logic; a processor-bus reset; one reset per downstream port; a bus-fatal reset; an output-safe enable; and a permit for link training. A three-bit code reports the highest reset class that is active.

Power-good is the only source that clears sticky state. Its assertion takes effect at once. Its release is synchronized to the clock. The hard class is driven by the external pin or by a configuration request, and it resets everything except sticky state. A processor-only request touches only the processor-bus reset. A targeted request touches only the port it selects. A fatal error latches the bus-fatal reset, and only a power-good cycle clears it. A higher class absorbs any lower one. The priority order, from highest to lowest, is power-good, hard, bus-fatal, targeted, processor-only.

Top module: `reset_class_hub`

## Requirements
- R1: `sticky_rst_n` goes low as soon as `pwr_ok_async` falls, with no clock edge needed. It goes high on the SYNC_STAGES-th (default 2) rising clock edge after `pwr_ok_async` rises. No other source moves it.
- R2: While power-good reset is active, the following all hold: `core_rst_n`, `cpu_rst_n`, every `port_rst_n` bit and `bus_fatal_rst_n` are low, `out_safe` is 1, `link_train_ok` is 0 and `reset_class` is 5. Power-good reset also clears any latched fatal state.
- R3: The external pin is synchronized through SYNC_STAGES flops. Its synchronized value reads as "asserted" until that many edges after power-good release. While the synchronized pin is low, the hard class is active. In the hard class, `core_rst_n`, `cpu_rst_n` and all `port_rst_n` are low and `out_safe` is 1, while `sticky_rst_n` stays high.
- R4: A configuration request with `cfg_req_kind`=0 (hard) holds the hard class for exactly HOLD_CYCLES (default 16) cycles. The hold starts at the clock edge that samples the request.
- R5: A request with kind 1 (processor-only) holds `cpu_rst_n` low for HOLD_CYCLES cycles. During that hold, `core_rst_n`, `sticky_rst_n`, `port_rst_n`, `out_safe` and `link_train_ok` do not change.
- R6: A request with kind 2 (targeted) holds low only `port_rst_n[cfg_req_port]`, for HOLD_CYCLES cycles. The block ignores a port index of NPORTS or more, and it ignores kind 3.
- R7: A `fatal_err` pulse, sampled at a clock edge, drives `bus_fatal_rst_n` low from that edge onward. It stays low through hard resets, and only a power-good reset releases it.
- R8: Absorption. A hard class or a latched fatal state cancels any running processor-only or targeted hold one edge after it becomes active, and it drops new ones. While the hard class is active, the block ignores `fatal_err`.
- R9: `reset_class` reports the highest active class with this encoding: 0 none, 1 processor-only, 2 targeted, 3 bus-fatal, 4 hard, 5 power-good.
- R10: `link_train_ok` is 1 only when power-good is released and the hard class is inactive.
- R11: A new request of the same class during a hold restarts that hold at the full HOLD_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_ok_async | input | 1 | Asynchronous power-good, high when supplies are stable |
| ext_rst_n | input | 1 | External hard-reset pin, active low, asynchronous |
| cfg_req_valid | input | 1 | One-cycle configuration reset request strobe |
| cfg_req_kind | input | 2 | 0 hard, 1 processor-only, 2 targeted, 3 no action |
| cfg_req_port | input | PORT_W (3) | Target port for kind 2 |
| fatal_err | input | 1 | Internal fatal bus error pulse |
| sticky_rst_n | output | 1 | Reset for sticky state, active low |
| core_rst_n | output | 1 | Reset for logic and non-sticky state, active low |
| cpu_rst_n | output | 1 | Processor-bus reset, active low |
| port_rst_n | output | NPORTS (6) | Per-port downstream resets, active low |
| bus_fatal_rst_n | output | 1 | Latched bus-fatal reset, active low |
| out_safe | output | 1 | Drive outputs to safe levels / tri-state |
| link_train_ok | output | 1 | Link training permitted |
| reset_class | output | 3 | Highest active reset class |

## Verification
Every output here is decoded directly from a few counters and flags, so a wrong internal value appears at the ports in the same cycle. A hold counter that is off by one shows up as a reset pulse one cycle too long or too short. A fatal flag that is lost or set wrongly flips `bus_fatal_rst_n` and `reset_class` at once. A synchronizer with the wrong depth moves the power-up release order by whole cycles. The bench compares every output against a behavioural model on every cycle. It therefore catches each of these faults within the first cycle in which it becomes visible. It also times the hold lengths directly, and it checks at the ports that absorbed requests leave no effect.

// File: rtl/rch_pkg.sv
package rch_pkg;

   typedef enum logic [2:0] {
      RC_NONE   = 3'd0,
      RC_PROC   = 3'd1,
      RC_TARGET = 3'd2,
      RC_FATAL  = 3'd3,
      RC_HARD   = 3'd4,
      RC_POWER  = 3'd5
   } rst_class_e;

   typedef enum logic [1:0] {
      REQ_HARD = 2'd0,
      REQ_PROC = 2'd1,
      REQ_PORT = 2'd2,
      REQ_NOP  = 2'd3
   } req_kind_e;

   // Highest-priority class wins
   function automatic rst_class_e pick_class(input logic pg_ok,
                                             input logic hard,
                                             input logic fatal,
                                             input logic tgt,
                                             input logic proc);
      rst_class_e c;
      if (!pg_ok)      c = RC_POWER;
      else if (hard)   c = RC_HARD;
      else if (fatal)  c = RC_FATAL;
      else if (tgt)    c = RC_TARGET;
      else if (proc)   c = RC_PROC;
      else             c = RC_NONE;
      return c;
   endfunction

endpackage

// File: rtl/rch_pg_sync.sv
// Power-good reset synchronizer: asserts asynchronously, releases after STAGES edges.
module rch_pg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic pwr_ok_async,
   output logic pg_ok
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rch_pg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stg;

   always_ff @(posedge clk or negedge pwr_ok_async) begin
      if (!pwr_ok_async) stg <= '0;
      else               stg <= {stg[STAGES-2:0], 1'b1};
   end

   assign pg_ok = stg[STAGES-1];

   // Once released with power still good, the release must not glitch.
   assert_pg_release_stable_R1: assert property (
      @(posedge clk) disable iff (!pwr_ok_async) pg_ok |=> pg_ok)
      else $error("pg_ok dropped while power good held");

endmodule

// File: rtl/rch_level_sync.sv
// Plain multi-flop level synchronizer with a selectable reset value.
module rch_level_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rch_level_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RESET_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/rch_hold_timer.sv
// Down-counter that keeps a reset class active for HOLD cycles after a load.
module rch_hold_timer #(
   parameter int HOLD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic load,
   output logic active
);
   if (HOLD < 1) begin : g_bad_hold
      $error("rch_hold_timer: HOLD must be at least 1");
   end

   localparam int CW = $clog2(HOLD + 1);
   localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (load)       cnt <= HOLD_V;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign active = (cnt != '0);

   assert_load_starts_hold_R4: assert property (
      @(posedge clk) disable iff (!rst_n) (load && !clr) |=> active)
      else $error("hold did not start after load");

   assert_clear_stops_hold_R8: assert property (
      @(posedge clk) disable iff (!rst_n) clr |=> !active)
      else $error("hold still active after clear");

endmodule

// File: rtl/rch_req_decode.sv
// Splits a configuration request into per-class start strobes.
module rch_req_decode #(
   parameter int NPORTS = 6,
   parameter int PORT_W = 3
) (
   input  logic              valid,
   input  logic [1:0]        kind,
   input  logic [PORT_W-1:0] port,
   output logic              hard_go,
   output logic              proc_go,
   output logic [NPORTS-1:0] tgt_go
);
   import rch_pkg::*;

   if (NPORTS < 1) begin : g_bad_ports
      $error("rch_req_decode: NPORTS must be at least 1");
   end
   if ((1 << PORT_W) < NPORTS) begin : g_bad_width
      $error("rch_req_decode: PORT_W too narrow for NPORTS");
   end

   logic tgt_kind;

   assign hard_go  = valid && (kind == REQ_HARD);
   assign proc_go  = valid && (kind == REQ_PROC);
   assign tgt_kind = valid && (kind == REQ_PORT);

   for (genvar i = 0; i < NPORTS; i++) begin : g_port
      assign tgt_go[i] = tgt_kind && (port == PORT_W'(i));
   end

   always_comb begin
      assert_single_target_R6: assert ($onehot0(tgt_go))
         else $error("more than one port selected");
   end

endmodule

// File: rtl/reset_class_hub.sv
module reset_class_hub #(
   parameter int NPORTS      = 6,
   parameter int HOLD_CYCLES = 16,
   parameter int SYNC_STAGES = 2,
   localparam int PORT_W     = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic              clk,
   input  logic              pwr_ok_async,
   input  logic              ext_rst_n,
   input  logic              cfg_req_valid,
   input  logic [1:0]        cfg_req_kind,
   input  logic [PORT_W-1:0] cfg_req_port,
   input  logic              fatal_err,
   output logic              sticky_rst_n,
   output logic              core_rst_n,
   output logic              cpu_rst_n,
   output logic [NPORTS-1:0] port_rst_n,
   output logic              bus_fatal_rst_n,
   output logic              out_safe,
   output logic              link_train_ok,
   output logic [2:0]        reset_class
);
   import rch_pkg::*;

   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("reset_class_hub: HOLD_CYCLES must be at least 1");
   end
   if (NPORTS < 1) begin : g_bad_ports
      $error("reset_class_hub: NPORTS must be at least 1");
   end

   logic              pg_ok;
   logic              pin_n_s;
   logic              hard_go, proc_go;
   logic [NPORTS-1:0] tgt_go;
   logic              hard_cfg_act, hard_act;
   logic              proc_act;
   logic [NPORTS-1:0] tgt_act;
   logic              fatal_q;
   logic              block_low;

   // Power-good domain: asynchronous assert, synchronous release
   rch_pg_sync #(.STAGES(SYNC_STAGES)) i_pg_sync (
      .clk          (clk),
      .pwr_ok_async (pwr_ok_async),
      .pg_ok        (pg_ok)
   );

   // External pin; reads as asserted until synchronized after power-good
   rch_level_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) i_pin_sync (
      .clk   (clk),
      .rst_n (pg_ok),
      .d     (ext_rst_n),
      .q     (pin_n_s)
   );

   rch_req_decode #(.NPORTS(NPORTS), .PORT_W(PORT_W)) i_decode (
      .valid   (cfg_req_valid),
      .kind    (cfg_req_kind),
      .port    (cfg_req_port),
      .hard_go (hard_go),
      .proc_go (proc_go),
      .tgt_go  (tgt_go)
   );

   // Hard class: pin or configuration hold
   rch_hold_timer #(.HOLD(HOLD_CYCLES)) i_hard_hold (
      .clk    (clk),
      .rst_n  (pg_ok),
      .clr    (1'b0),
      .load   (hard_go),
      .active (hard_cfg_act)
   );

   assign hard_act  = !pin_n_s || hard_cfg_act;
   assign block_low = hard_act || fatal_q;

   // Unrecoverable bus-fatal state, cleared by power-good only
   always_ff @(posedge clk or negedge pg_ok) begin
      if (!pg_ok) fatal_q <= 1'b0;
      else        fatal_q <= fatal_q || (fatal_err && !hard_act);
   end

   rch_hold_timer #(.HOLD(HOLD_CYCLES)) i_proc_hold (
      .clk    (clk),
      .rst_n  (pg_ok),
      .clr    (block_low),
      .load   (proc_go),
      .active (proc_act)
   );

   for (genvar p = 0; p < NPORTS; p++) begin : g_port_hold
      rch_hold_timer #(.HOLD(HOLD_CYCLES)) i_port_hold (
         .clk    (clk),
         .rst_n  (pg_ok),
         .clr    (block_low),
         .load   (tgt_go[p]),
         .active (tgt_act[p])
      );
      assign port_rst_n[p] = pg_ok && !hard_act && !tgt_act[p];
   end

   assign sticky_rst_n    = pg_ok;
   assign core_rst_n      = pg_ok && !hard_act;
   assign cpu_rst_n       = pg_ok && !hard_act && !proc_act;
   assign bus_fatal_rst_n = pg_ok && !fatal_q;
   assign out_safe        = !pg_ok || hard_act;
   assign link_train_ok   = pg_ok && !hard_act;
   assign reset_class     = pick_class(pg_ok, hard_act, fatal_q, |tgt_act, proc_act);

   // ---------------- assertions ----------------
   assert_pg_reset_reach_R2: assert property (
      @(posedge clk) !sticky_rst_n |->
         (!core_rst_n && !cpu_rst_n && !bus_fatal_rst_n && out_safe && !link_train_ok))
      else $error("power-good reset does not cover every output");

   assert_hard_reach_R3: assert property (
      @(posedge clk) !core_rst_n |-> (out_safe && !cpu_rst_n && (port_rst_n == '0)))
      else $error("hard reset does not cover processor, ports and safe enable");

   assert_fatal_latched_R7: assert property (
      @(posedge clk) disable iff (!pg_ok) fatal_q |=> fatal_q)
      else $error("fatal state released without power-good");

   assert_hard_absorbs_R8: assert property (
      @(posedge clk) disable iff (!pg_ok) hard_act |=> (!proc_act && (tgt_act == '0)))
      else $error("lower class survived hard reset");

   assert_class_hard_R9: assert property (
      @(posedge clk) disable iff (!pg_ok) (reset_class == RC_HARD) |-> !link_train_ok)
      else $error("link permitted while hard class reported");

   assert_link_gate_R10: assert property (
      @(posedge clk) link_train_ok |-> (sticky_rst_n && core_rst_n))
      else $error("link permitted during reset");

endmodule

// File: tb/test_reset_class_hub.sv
`timescale 1ns/1ps
module test_reset_class_hub;
   localparam int NP = 6;
   localparam int H  = 16;
   localparam int S  = 2;

   logic          clk = 1'b0;
   logic          pwr_ok_async = 1'b0;
   logic          ext_rst_n = 1'b1;
   logic          cfg_req_valid = 1'b0;
   logic [1:0]    cfg_req_kind = 2'd3;
   logic [2:0]    cfg_req_port = 3'd0;
   logic          fatal_err = 1'b0;
   logic          sticky_rst_n, core_rst_n, cpu_rst_n, bus_fatal_rst_n;
   logic          out_safe, link_train_ok;
   logic [NP-1:0] port_rst_n;
   logic [2:0]    reset_class;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   reset_class_hub #(.NPORTS(NP), .HOLD_CYCLES(H), .SYNC_STAGES(S)) i_reset_class_hub (
      .clk(clk), .pwr_ok_async(pwr_ok_async), .ext_rst_n(ext_rst_n),
      .cfg_req_valid(cfg_req_valid), .cfg_req_kind(cfg_req_kind),
      .cfg_req_port(cfg_req_port), .fatal_err(fatal_err),
      .sticky_rst_n(sticky_rst_n), .core_rst_n(core_rst_n), .cpu_rst_n(cpu_rst_n),
      .port_rst_n(port_rst_n), .bus_fatal_rst_n(bus_fatal_rst_n),
      .out_safe(out_safe), .link_train_ok(link_train_ok), .reset_class(reset_class)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [S-1:0] m_pg = '0;
   logic [S-1:0] m_pin = '0;
   int  m_h = 0, m_p = 0;
   int  m_t [NP];
   bit  m_f = 1'b0;

   initial foreach (m_t[i]) m_t[i] = 0;

   always @(posedge clk) begin
      bit pgok, hact, blk;
      pgok = m_pg[S-1];
      hact = !m_pin[S-1] || (m_h != 0);
      blk  = hact || m_f;
      if (!pwr_ok_async) m_pg = '0;
      else               m_pg = {m_pg[S-2:0], 1'b1};
      if (!pwr_ok_async || !pgok) begin
         m_pin = '0; m_h = 0; m_p = 0; m_f = 1'b0;
         foreach (m_t[i]) m_t[i] = 0;
      end else begin
         m_pin = {m_pin[S-2:0], ext_rst_n};
         if (cfg_req_valid && cfg_req_kind == 2'd0) m_h = H;
         else if (m_h != 0) m_h = m_h - 1;
         m_f = m_f || (fatal_err && !hact);
         if (blk) m_p = 0;
         else if (cfg_req_valid && cfg_req_kind == 2'd1) m_p = H;
         else if (m_p != 0) m_p = m_p - 1;
         foreach (m_t[i]) begin
            if (blk) m_t[i] = 0;
            else if (cfg_req_valid && cfg_req_kind == 2'd2 && int'(cfg_req_port) == i) m_t[i] = H;
            else if (m_t[i] != 0) m_t[i] = m_t[i] - 1;
         end
      end
   end

   always @(negedge clk) begin
      bit pg, ha, ta;
      int cls;
      logic [NP-1:0] ep;
      #1;
      if (!done) begin
         pg = m_pg[S-1];
         ha = !m_pin[S-1] || (m_h != 0);
         ta = 1'b0;
         foreach (m_t[i]) begin
            ep[i] = pg && !ha && (m_t[i] == 0);
            if (m_t[i] != 0) ta = 1'b1;
         end
         if (!pg) cls = 5; else if (ha) cls = 4; else if (m_f) cls = 3;
         else if (ta) cls = 2; else if (m_p != 0) cls = 1; else cls = 0;
         chk("R1", "sticky_rst_n", int'(sticky_rst_n), int'(pg));
         chk("R3", "core_rst_n", int'(core_rst_n), int'(pg && !ha));
         chk("R5", "cpu_rst_n", int'(cpu_rst_n), int'(pg && !ha && m_p == 0));
         chk("R6", "port_rst_n", int'(port_rst_n), int'(ep));
         chk("R7", "bus_fatal_rst_n", int'(bus_fatal_rst_n), int'(pg && !m_f));
         chk("R2", "out_safe", int'(out_safe), int'(!pg || ha));
         chk("R10", "link_train_ok", int'(link_train_ok), int'(pg && !ha));
         chk("R9", "reset_class", int'(reset_class), cls);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #2;
   endtask

   // Request sampled at the next rising edge; returns at the following negedge + 1
   task automatic req(input logic [1:0] kind, input logic [2:0] port);
      @(negedge clk); #2;
      cfg_req_valid = 1'b1; cfg_req_kind = kind; cfg_req_port = port;
      @(negedge clk); #1;
      cfg_req_valid = 1'b0; cfg_req_kind = 2'd3;
   endtask

   task automatic ferr_pulse();
      @(negedge clk); #2;
      fatal_err = 1'b1;
      @(negedge clk); #1;
      fatal_err = 1'b0;
   endtask

   initial begin
      int n;
      // reset state
      idle(5);
      chk("R2", "class under power-good reset", int'(reset_class), 5);
      chk("R2", "ports under power-good reset", int'(port_rst_n), 0);
      pwr_ok_async = 1'b1;
      idle(10);
      chk("R9", "class idle after power-up", int'(reset_class), 0);
      chk("R10", "link permitted after power-up", int'(link_train_ok), 1);

      // R5: processor-only hold length, logic untouched
      req(2'd1, 3'd0);
      n = 0;
      for (int i = 0; i < 30; i++) begin
         if (!cpu_rst_n) n++;
         if (!core_rst_n) n += 100;
         @(negedge clk); #1;
      end
      chk("R5", "processor-only hold cycles", n, H);

      // R6: targeted port 2 only
      req(2'd2, 3'd2);
      n = 0;
      for (int i = 0; i < 30; i++) begin
         if (!port_rst_n[2]) n++;
         if (port_rst_n[0] == 1'b0) n += 100;
         @(negedge clk); #1;
      end
      chk("R6", "targeted hold cycles on port 2", n, H);

      // R6: out-of-range port and no-action kind ignored
      req(2'd2, 3'd7);
      req(2'd3, 3'd1);
      idle(2);
      chk("R6", "ignored requests leave ports released", int'(port_rst_n), (1 << NP) - 1);
      chk("R6", "ignored requests leave class", int'(reset_class), 0);

      // R11: restart during hold: 10 samples, 2 unobserved, then a full 16
      req(2'd1, 3'd0);
      n = 0;
      for (int i = 0; i < 10; i++) begin
         if (!cpu_rst_n) n++;
         @(negedge clk); #1;
      end
      req(2'd1, 3'd0);
      for (int i = 0; i < 30; i++) begin
         if (!cpu_rst_n) n++;
         @(negedge clk); #1;
      end
      chk("R11", "restarted hold observed cycles", n, 10 + H);

      // R4: configuration hard reset
      req(2'd0, 3'd0);
      n = 0;
      for (int i = 0; i < 30; i++) begin
         if (!core_rst_n) n++;
         if (!sticky_rst_n) n += 100;
         @(negedge clk); #1;
      end
      chk("R4", "configuration hard hold cycles", n, H);

      // R3/R8: pin hard reset absorbs a targeted request
      @(negedge clk); #2; ext_rst_n = 1'b0;
      idle(4);
      chk("R3", "sticky kept during pin hard reset", int'(sticky_rst_n), 1);
      req(2'd2, 3'd1);
      ferr_pulse();
      @(negedge clk); #2; ext_rst_n = 1'b1;
      idle(6);
      chk("R8", "targeted request dropped under hard", int'(port_rst_n[1]), 1);
      chk("R8", "fatal ignored during hard", int'(bus_fatal_rst_n), 1);

      // R8: targeted in progress cancelled by fatal
      req(2'd2, 3'd4);
      idle(3);
      ferr_pulse();
      idle(2);
      chk("R8", "running targeted hold cancelled by fatal", int'(port_rst_n[4]), 1);
      chk("R9", "class bus-fatal", int'(reset_class), 3);
      req(2'd1, 3'd0);
      n = 0;
      for (int i = 0; i < 20; i++) begin
         if (!cpu_rst_n) n++;
         @(negedge clk); #1;
      end
      chk("R8", "processor request dropped while fatal", n, 0);

      // R7: fatal survives hard reset
      req(2'd0, 3'd0);
      idle(2);
      chk("R9", "hard outranks fatal", int'(reset_class), 4);
      idle(H + 4);
      chk("R7", "fatal survives hard reset", int'(bus_fatal_rst_n), 0);

      // R1: asynchronous assert, synchronized release, fatal cleared
      @(negedge clk); #2; pwr_ok_async = 1'b0;
      #1;
      chk("R1", "sticky asserts without clock edge", int'(sticky_rst_n), 0);
      idle(3);
      pwr_ok_async = 1'b1;
      @(posedge clk); #1;
      chk("R1", "still held after first edge", int'(sticky_rst_n), 0);
      @(posedge clk); #1;
      chk("R1", "released after second edge", int'(sticky_rst_n), 1);
      chk("R3", "core held until pin synchronized", int'(core_rst_n), 0);
      idle(4);
      chk("R7", "fatal cleared by power-good", int'(bus_fatal_rst_n), 1);

      // R10: pin held low through power-up keeps link blocked
      @(negedge clk); #2; pwr_ok_async = 1'b0; ext_rst_n = 1'b0;
      idle(3);
      pwr_ok_async = 1'b1;
      idle(8);
      chk("R10", "link blocked with pin asserted", int'(link_train_ok), 0);
      ext_rst_n = 1'b1;
      idle(4);
      chk("R10", "link permitted after pin release", int'(link_train_ok), 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule